// File: doc/BRIEF.md
# PS/2 Scan-Code Display Receiver

This block listens to a keyboard that only transmits over a two-wire PS/2 link: a keyboard clock and a data line, both inputs here and never driven. It brings both lines into the system clock domain and filters the keyboard clock against glitches. On each filtered falling edge it samples one bit and builds 11-bit frames. Frames with a bad parity or stop bit are dropped.

Key presses and releases arrive as short byte sequences. The extended prefix (E0) and the release prefix (F0) are consumed silently. The next non-prefix byte, which names the key, is held and shown as two hexadecimal digits on a pair of active-low seven-segment displays. A press and the matching release of a key therefore leave the same code on the displays. If a frame stalls part-way through, a timeout returns the receiver to idle, so the next frame starts clean.

Top module: `ps2_scan_display`

## Requirements
- R1: After reset both displays show digit 0. Segment outputs are active-low, with bit 0 = segment a up to bit 6 = segment g. The lit-segment patterns (1 = lit, as gfedcba) for digits 0..F are 3F 06 5B 4F 66 6D 7D 07 7F 6F 77 7C 39 5E 79 71, and each output is the bitwise inverse of its pattern.
- R2: A frame is a low start bit, eight data bits least-significant first, an odd-parity bit and a high stop bit. A valid frame whose byte is not a prefix is held. Its upper nibble is shown on `seg_hi_o` and its lower nibble on `seg_lo_o`.
- R3: Each bit is sampled on a falling edge of the keyboard clock. The displays reflect a valid byte within FILT_LEN+8 system clocks of the stop bit's falling edge.
- R4: A frame whose data and parity bits together hold an even number of ones is discarded, and the displays are unchanged.
- R5: A frame whose stop bit is low is discarded, and the displays are unchanged.
- R6: Bytes E0 and F0 are accepted but leave the displays unchanged. The following non-prefix byte is shown, so the press and release of a key show the same code.
- R7: A low pulse on the keyboard clock lasting fewer than FILT_LEN system clocks is not treated as an edge.
- R8: If no falling edge arrives for TIMEOUT_CYC system clocks while a frame is in progress, the receiver returns to idle. The next complete frame is then decoded correctly.
- R9: A falling edge that finds the data line high while idle does not start a frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ps2_clk_i | input | 1 | Keyboard clock line |
| ps2_dat_i | input | 1 | Keyboard data line |
| seg_hi_o | output | 7 | Upper-nibble digit, active-low, bit 0 = a |
| seg_lo_o | output | 7 | Lower-nibble digit, active-low, bit 0 = a |

## Verification
A wrong bit counter or shift register shows at the ports as a wrong or misaligned code on the displays. It appears within FILT_LEN+8 clocks of the next stop edge, and it stays wrong until a later valid frame. A prefix byte latched by mistake shows E0 or F0 in place of the held key. A missing timeout or start check shows up one frame later, as corrupted or dropped codes. A glitch taken as an edge shifts every following bit of that frame. The reference model compares both digits on every clock while the keyboard clock is high, and it also checks the latency window at each stop bit.

// File: rtl/ps2_scan_pkg.sv
package ps2_scan_pkg;
  localparam logic [7:0] PFX_EXT = 8'hE0;
  localparam logic [7:0] PFX_REL = 8'hF0;
  localparam int unsigned FRAME_LAST = 10;

  // active-low seven-segment, bit0 = a .. bit6 = g
  function automatic logic [6:0] hex_seg_n(input logic [3:0] v);
    logic [6:0] on;
    case (v)
      4'h0: on = 7'h3F; 4'h1: on = 7'h06; 4'h2: on = 7'h5B; 4'h3: on = 7'h4F;
      4'h4: on = 7'h66; 4'h5: on = 7'h6D; 4'h6: on = 7'h7D; 4'h7: on = 7'h07;
      4'h8: on = 7'h7F; 4'h9: on = 7'h6F; 4'hA: on = 7'h77; 4'hB: on = 7'h7C;
      4'hC: on = 7'h39; 4'hD: on = 7'h5E; 4'hE: on = 7'h79; default: on = 7'h71;
    endcase
    return ~on;
  endfunction
endpackage

// File: rtl/ps2_line_sync.sv
module ps2_line_sync #(
  parameter int unsigned FILT_LEN = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ps2_clk_i,
  input  logic ps2_dat_i,
  output logic fall_o,
  output logic dat_o
);
  localparam int unsigned FW = $clog2(FILT_LEN);

  logic [1:0]    clk_ff, dat_ff;
  logic          clk_s, clk_f, fall_q;
  logic [FW-1:0] fcnt_q;

  assign clk_s = clk_ff[1];
  assign dat_o = dat_ff[1];
  assign fall_o = fall_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      clk_ff <= 2'b11;
      dat_ff <= 2'b11;
    end else begin
      clk_ff <= {clk_ff[0], ps2_clk_i};
      dat_ff <= {dat_ff[0], ps2_dat_i};
    end
  end

  // filtered clock follows synced clock only after FILT_LEN stable cycles
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      clk_f  <= 1'b1;
      fcnt_q <= '0;
      fall_q <= 1'b0;
    end else begin
      fall_q <= 1'b0;
      if (clk_s == clk_f) begin
        fcnt_q <= '0;
      end else if (fcnt_q == FW'(FILT_LEN - 1)) begin
        clk_f  <= clk_s;
        fcnt_q <= '0;
        fall_q <= ~clk_s;
      end else begin
        fcnt_q <= fcnt_q + 1'b1;
      end
    end
  end

  p_filter_stable_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(clk_f) |-> ($past(clk_s) == clk_f));
  p_fall_low_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fall_q |-> !clk_f);
endmodule

// File: rtl/ps2_frame_rx.sv
module ps2_frame_rx
  import ps2_scan_pkg::*;
#(
  parameter int unsigned TIMEOUT_CYC = 250000
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       fall_i,
  input  logic       dat_i,
  output logic [7:0] byte_o,
  output logic       vld_o
);
  localparam int unsigned TW = $clog2(TIMEOUT_CYC);

  logic [3:0]    cnt_q;
  logic [7:0]    sh_q;
  logic          par_q, vld_q;
  logic [TW-1:0] to_q;

  assign byte_o = sh_q;
  assign vld_o  = vld_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      sh_q  <= '0;
      par_q <= 1'b0;
      vld_q <= 1'b0;
      to_q  <= '0;
    end else begin
      vld_q <= 1'b0;
      if (fall_i) begin
        to_q <= '0;
        if (cnt_q == 4'd0) begin
          if (!dat_i) cnt_q <= 4'd1;
        end else if (cnt_q <= 4'd8) begin
          sh_q  <= {dat_i, sh_q[7:1]};
          cnt_q <= cnt_q + 4'd1;
        end else if (cnt_q == 4'd9) begin
          par_q <= dat_i;
          cnt_q <= 4'd10;
        end else begin
          cnt_q <= '0;
          vld_q <= dat_i & (^sh_q ^ par_q);
        end
      end else if (cnt_q != 4'd0) begin
        if (to_q == TW'(TIMEOUT_CYC - 1)) begin
          cnt_q <= '0;
          to_q  <= '0;
        end else begin
          to_q <= to_q + 1'b1;
        end
      end
    end
  end

  p_cnt_range_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= 4'(FRAME_LAST));
  p_vld_stop_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vld_q |-> ($past(cnt_q) == 4'(FRAME_LAST) && $past(dat_i) && $past(fall_i)));
  p_timeout_idle_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q != 4'd0 && !fall_i && to_q == TW'(TIMEOUT_CYC - 1)) |=> (cnt_q == 4'd0));
  p_start_low_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fall_i && cnt_q == 4'd0 && dat_i) |=> (cnt_q == 4'd0));
endmodule

// File: rtl/ps2_code_hold.sv
module ps2_code_hold
  import ps2_scan_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       vld_i,
  input  logic [7:0] byte_i,
  output logic [7:0] key_o
);
  logic [7:0] key_q;
  logic       is_pfx;

  assign is_pfx = (byte_i == PFX_EXT) || (byte_i == PFX_REL);
  assign key_o  = key_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              key_q <= '0;
    else if (vld_i && !is_pfx) key_q <= byte_i;
  end

  p_prefix_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vld_i && (byte_i == 8'hE0 || byte_i == 8'hF0)) |=> $stable(key_q));
  p_latch_key_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vld_i && byte_i != 8'hE0 && byte_i != 8'hF0) |=> (key_q == $past(byte_i)));
  p_no_vld_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !vld_i |=> $stable(key_q));
endmodule

// File: rtl/ps2_scan_display.sv
module ps2_scan_display
  import ps2_scan_pkg::*;
#(
  parameter int unsigned FILT_LEN    = 8,
  parameter int unsigned TIMEOUT_CYC = 250000
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       ps2_clk_i,
  input  logic       ps2_dat_i,
  output logic [6:0] seg_hi_o,
  output logic [6:0] seg_lo_o
);
  localparam int unsigned NDIG = 2;

  logic       fall, dat, vld;
  logic [7:0] rx_byte, key;
  logic [6:0] seg_w [NDIG];

  ps2_line_sync #(.FILT_LEN(FILT_LEN)) u_sync (
    .clk_i, .rst_ni, .ps2_clk_i, .ps2_dat_i,
    .fall_o(fall), .dat_o(dat)
  );

  ps2_frame_rx #(.TIMEOUT_CYC(TIMEOUT_CYC)) u_rx (
    .clk_i, .rst_ni, .fall_i(fall), .dat_i(dat),
    .byte_o(rx_byte), .vld_o(vld)
  );

  ps2_code_hold u_hold (
    .clk_i, .rst_ni, .vld_i(vld), .byte_i(rx_byte), .key_o(key)
  );

  for (genvar d = 0; d < NDIG; d++) begin : g_dig
    assign seg_w[d] = hex_seg_n(key[4*d +: 4]);
  end

  assign seg_lo_o = seg_w[0];
  assign seg_hi_o = seg_w[1];

  p_digit_lit_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seg_hi_o != 7'h7F) && (seg_lo_o != 7'h7F));
endmodule

// File: tb/ps2_scan_display_tb.sv
module ps2_scan_display_tb;
  localparam int FILT = 4;
  localparam int TO   = 400;
  localparam int HALF = 40;

  logic clk = 1'b0, rst_n = 1'b0;
  logic ps2_clk_d = 1'b1, ps2_dat_d = 1'b1;
  logic [6:0] seg_hi, seg_lo;
  logic [7:0] exp_key = 8'h00;
  bit   cmp_en = 1'b0, done = 1'b0;
  int   checks = 0, errors = 0;

  always #4 clk = ~clk;

  ps2_scan_display #(.FILT_LEN(FILT), .TIMEOUT_CYC(TO)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .ps2_clk_i(ps2_clk_d), .ps2_dat_i(ps2_dat_d),
    .seg_hi_o(seg_hi), .seg_lo_o(seg_lo)
  );

  function automatic logic [6:0] seg_ref(input logic [3:0] n);
    logic [6:0] p;
    case (n)
      0: p = 7'h3F; 1: p = 7'h06; 2: p = 7'h5B; 3: p = 7'h4F;
      4: p = 7'h66; 5: p = 7'h6D; 6: p = 7'h7D; 7: p = 7'h07;
      8: p = 7'h7F; 9: p = 7'h6F; 10: p = 7'h77; 11: p = 7'h7C;
      12: p = 7'h39; 13: p = 7'h5E; 14: p = 7'h79; default: p = 7'h71;
    endcase
    return ~p;
  endfunction

  // model compare every clock while the keyboard clock rests high (R2)
  always @(negedge clk) begin
    if (cmp_en && ps2_clk_d) begin
      checks++;
      if ({seg_hi, seg_lo} !== {seg_ref(exp_key[7:4]), seg_ref(exp_key[3:0])}) begin
        errors++;
        $display("FAIL R2 model: got %h/%h exp %h/%h", seg_hi, seg_lo,
                 seg_ref(exp_key[7:4]), seg_ref(exp_key[3:0]));
      end
    end
  end

  task automatic check_disp(input string tag, input logic [7:0] k);
    @(negedge clk);
    checks++;
    if (seg_hi !== seg_ref(k[7:4]) || seg_lo !== seg_ref(k[3:0])) begin
      errors++;
      $display("FAIL %s: got %h/%h exp %h/%h", tag, seg_hi, seg_lo,
               seg_ref(k[7:4]), seg_ref(k[3:0]));
    end
  endtask

  task automatic clks(input int n);
    repeat (n) @(posedge clk);
  endtask

  // glitch_bit >= 0 inserts a short low pulse in that bit's high phase
  task automatic send_frame(input logic [7:0] b, input bit bad_par, input bit bad_stop,
                            input int glitch_bit);
    logic [10:0] f;
    bit ok;
    f = {~bad_stop, (~^b) ^ bad_par, b, 1'b0};
    ok = !bad_par && !bad_stop && b != 8'hE0 && b != 8'hF0;
    for (int i = 0; i < 11; i++) begin
      ps2_dat_d <= f[i];
      clks(HALF/2);
      ps2_clk_d <= 1'b0;
      if (i == 10) begin
        if (ok) exp_key = b;
        clks(FILT + 8);
        check_disp("R3 latency", exp_key);
        clks(HALF - FILT - 9);
      end else begin
        clks(HALF);
      end
      ps2_clk_d <= 1'b1;
      if (i == glitch_bit) begin
        clks(4);
        ps2_clk_d <= 1'b0;
        clks(FILT - 2);
        ps2_clk_d <= 1'b1;
        clks(HALF/2 - 4 - (FILT - 2));
      end else begin
        clks(HALF/2);
      end
    end
    clks(100);
  endtask

  task automatic send_bits(input logic [10:0] f, input int n);
    for (int i = 0; i < n; i++) begin
      ps2_dat_d <= f[i];
      clks(HALF/2);
      ps2_clk_d <= 1'b0;
      clks(HALF);
      ps2_clk_d <= 1'b1;
      clks(HALF/2);
    end
  endtask

  initial begin
    clks(5);
    rst_n = 1'b1;
    clks(5);
    check_disp("R1 reset shows 00", 8'h00);
    cmp_en = 1'b1;

    send_frame(8'h76, 0, 0, -1); check_disp("R2 byte 76", 8'h76);
    send_frame(8'h8C, 0, 0, -1); check_disp("R2 byte 8C", 8'h8C);
    send_frame(8'h3E, 0, 0, -1); check_disp("R2 byte 3E", 8'h3E);
    send_frame(8'hDB, 0, 0, -1); check_disp("R2 byte DB", 8'hDB);

    send_frame(8'h1C, 0, 0, -1);
    send_frame(8'hF0, 0, 0, -1); check_disp("R6 F0 ignored", 8'h1C);
    send_frame(8'h1C, 0, 0, -1); check_disp("R6 release same", 8'h1C);
    send_frame(8'hE0, 0, 0, -1); check_disp("R6 E0 ignored", 8'h1C);
    send_frame(8'h75, 0, 0, -1); check_disp("R6 ext press", 8'h75);
    send_frame(8'hE0, 0, 0, -1);
    send_frame(8'hF0, 0, 0, -1); check_disp("R6 E0 F0 ignored", 8'h75);
    send_frame(8'h75, 0, 0, -1); check_disp("R6 ext release", 8'h75);

    send_frame(8'h33, 1, 0, -1); check_disp("R4 bad parity", 8'h75);
    send_frame(8'h44, 0, 1, -1); check_disp("R5 bad stop", 8'h75);
    send_frame(8'h12, 0, 0, -1); check_disp("R4 recover", 8'h12);

    send_frame(8'hA5, 0, 0, 4);  check_disp("R7 glitch ignored", 8'hA5);

    send_bits({1'b1, 1'b1, 8'hFF, 1'b0}, 5);
    clks(TO + 50);
    check_disp("R8 partial no change", 8'hA5);
    send_frame(8'h5A, 0, 0, -1); check_disp("R8 after timeout", 8'h5A);

    ps2_dat_d <= 1'b1;
    clks(10);
    send_bits(11'h7FF, 1);
    clks(50);
    send_frame(8'h29, 0, 0, -1); check_disp("R9 high start ignored", 8'h29);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog R1-all: got hang exp completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule